// File: doc/BRIEF.md
# Interrupt Event Translation Walker

This block turns a message-signalled interrupt, named by a device number and an event number, into a target processor number and an interrupt ID. It reads three tables that software keeps in memory, one after another. First it reads the device table entry. That entry points to a per-device translation table, and the walker reads the translation entry for the event from it. The translation entry names a collection, so the walker then reads the collection table entry, which holds the target processor. When the walk succeeds, the block sends one set-pending or clear-pending strobe toward that target.

A request carries one of three operations. Trigger sets the interrupt pending. Clear removes the pending state. Discard removes the pending state and then erases the translation entry in memory.

Every walk ends with a one-cycle `done` pulse and one of three results:
- Continue: the walk completed.
- Ignore: a parameter or table entry was bad, so the command is dropped and the queue moves on.
- Stall: a memory access failed, so the queue must stop.

The table bases and the device, collection and processor counts are inputs. They must be held stable while a walk is in progress. All memory traffic goes through a single request/acknowledge port with an error flag.

Top module: `evt_xlate_top`

## Requirements
- R1: A device number greater than or equal to `devCount` ends the walk with result Ignore (1). No memory access is made.
- R2: The device entry is the 64-bit word at `devBase + devId*8`. Bit 0 is its valid flag. If the valid flag is clear, the result is Ignore (1).
- R3: Bits [5:1] of the device entry hold a size field s, and the device owns 2^(s+1) events. An event number at or beyond that count gives Ignore (1).
- R4: The translation table base is the device entry with its low 8 bits cleared. The entry for event e starts at base + 12*e. Its 8-byte low word is at that address, and its 4-byte high word is 8 bytes above it.
- R5: A translation entry is used only when its low-word bit 0 is set and bits [2:1] equal 01 (physical). The interrupt ID is low-word bits [8 +: IDW_INT]. The collection number is high-word bits [COLW-1:0]. Any other entry gives Ignore (1).
- R6: The collection entry is the 64-bit word at `colBase + colId*8`. Bit 0 is its valid flag and bits [16 +: PROCW] hold the target number. Any of these gives Ignore (1): a collection number greater than or equal to `colCount`, a clear valid flag, or a target greater than or equal to `cpuCount`.
- R7: The `op` encoding is 0 for trigger, 1 for clear and 2 for discard. A successful walk emits exactly one `pendStrobe` cycle, with `target` and `intId` valid. `pendSet` is 1 for trigger and 0 for clear and discard.
- R8: After its strobe, discard writes zero to the translation entry: first the 8-byte low word, then the 4-byte high word. If either write returns an error, the result is Stall (2). Only discard ever writes.
- R9: An error on any read ends the walk with result Stall (2) and no pending strobe.
- R10: `done` is high for exactly one cycle per accepted request. The `result` encoding is 0 for Continue, 1 for Ignore and 2 for Stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| op | input | 2 | Operation: 0 trigger, 1 clear, 2 discard |
| devId | input | DEVW | Device number |
| eventId | input | EVW | Event number |
| devBase | input | AW | Device table byte address |
| devCount | input | DEVW+1 | Number of device table entries |
| colBase | input | AW | Collection table byte address |
| colCount | input | COLW+1 | Number of collection entries |
| cpuCount | input | PROCW+1 | Number of target processors |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memWide | output | 1 | 1: 8-byte access, 0: 4-byte access |
| memAddr | output | AW | Byte address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Access completed this cycle |
| memErr | input | 1 | Access failed, qualified by memAck |
| memRdata | input | 64 | Read data, qualified by memAck |
| pendStrobe | output | 1 | Pending update for the target |
| pendSet | output | 1 | 1 sets pending, 0 clears it |
| target | output | PROCW | Target processor number |
| intId | output | IDW_INT | Interrupt ID |
| done | output | 1 | Walk finished |
| result | output | 2 | 0 continue, 1 ignore, 2 stall |

## Verification
The bench builds the walker with a 16-bit address, 4-bit device, collection and processor numbers and 8-bit event numbers. With these sizes all three tables fit in a 4 KB behavioural memory. The reduced widths also make the range boundaries easy to reach: device 8 against a count of 8, event 8 against a size field of 2, and collection 5 against a count of 4. Read and write faults can be placed at any single address, so a stall can be forced at the device read, at the high-word read and at the second write-back word.

// File: rtl/evt_xlate_pkg.sv
package evt_xlate_pkg;
  typedef enum logic [1:0] {OP_TRIGGER = 2'd0, OP_CLEAR = 2'd1, OP_DISCARD = 2'd2} opKind_e;
  typedef enum logic [1:0] {RES_CONTINUE = 2'd0, RES_IGNORE = 2'd1, RES_STALL = 2'd2} walkRes_e;
  typedef enum logic [1:0] {SEL_DEV, SEL_ITE_LO, SEL_ITE_HI, SEL_COL} addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     loadDev;
    logic     loadItel;
    logic     loadIteh;
    logic     loadCol;
    addrSel_e addrSel;
  } dpCtl_t;

  // checks evaluated by the datapath on the word being returned
  typedef struct packed {
    logic devOor;
    logic devOk;
    logic evtOor;
    logic iteOk;
    logic colOor;
    logic colOk;
    logic tgtOor;
  } dpFlag_t;
endpackage

// File: rtl/evt_xlate_dp.sv
module evt_xlate_dp
  import evt_xlate_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DEVW    = 8,
  parameter int EVW     = 16,
  parameter int COLW    = 8,
  parameter int PROCW   = 8,
  parameter int IDW_INT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [DEVW-1:0]    devId,
  input  logic [EVW-1:0]     eventId,
  input  logic [AW-1:0]      devBase,
  input  logic [DEVW:0]      devCount,
  input  logic [AW-1:0]      colBase,
  input  logic [COLW:0]      colCount,
  input  logic [PROCW:0]     cpuCount,
  input  logic [63:0]        memRdata,
  output dpFlag_t            flags,
  output logic [AW-1:0]      memAddr,
  output logic [63:0]        memWdata,
  output logic [PROCW-1:0]   target,
  output logic [IDW_INT-1:0] intId
);
  localparam int ITT_ALIGN = 8;
  localparam int INT_LSB   = 8;
  localparam int TGT_LSB   = 16;

  logic [DEVW-1:0]    devReg;
  logic [EVW-1:0]     evReg;
  logic [AW-1:0]      ittBase;
  logic [COLW-1:0]    colIdReg;
  logic [IDW_INT-1:0] intIdReg;
  logic [PROCW-1:0]   tgtReg;
  logic [EVW:0]       evShift;
  logic [AW-1:0]      iteLoAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devReg   <= '0;
      evReg    <= '0;
      ittBase  <= '0;
      colIdReg <= '0;
      intIdReg <= '0;
      tgtReg   <= '0;
    end else begin
      if (ctl.latchReq) begin
        devReg <= devId;
        evReg  <= eventId;
      end
      if (ctl.loadDev)  ittBase  <= {memRdata[AW-1:ITT_ALIGN], {ITT_ALIGN{1'b0}}};
      if (ctl.loadItel) intIdReg <= memRdata[INT_LSB +: IDW_INT];
      if (ctl.loadIteh) colIdReg <= memRdata[COLW-1:0];
      if (ctl.loadCol)  tgtReg   <= memRdata[TGT_LSB +: PROCW];
    end
  end

  // 12-byte translation entries: 8*e + 4*e
  assign iteLoAddr = ittBase + AW'({evReg, 3'b000}) + AW'({evReg, 2'b00});

  always_comb begin
    unique case (ctl.addrSel)
      SEL_DEV:    memAddr = devBase + AW'({devReg, 3'b000});
      SEL_ITE_LO: memAddr = iteLoAddr;
      SEL_ITE_HI: memAddr = iteLoAddr + AW'(8);
      default:    memAddr = colBase + AW'({colIdReg, 3'b000});
    endcase
  end

  assign evShift      = {1'b0, evReg} >> ({1'b0, memRdata[5:1]} + 6'd1);
  assign flags.devOor = {1'b0, devId} >= devCount;
  assign flags.devOk  = memRdata[0];
  assign flags.evtOor = evShift != '0;
  assign flags.iteOk  = memRdata[0] && (memRdata[2:1] == 2'b01);
  assign flags.colOor = {1'b0, memRdata[COLW-1:0]} >= colCount;
  assign flags.colOk  = memRdata[0];
  assign flags.tgtOor = {1'b0, memRdata[TGT_LSB +: PROCW]} >= cpuCount;

  assign memWdata = '0;
  assign target   = tgtReg;
  assign intId    = intIdReg;

  AST_TGT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.loadCol) |-> ({1'b0, target} < cpuCount)) else $error("target out of range"); // R6
endmodule

// File: rtl/evt_xlate_ctl.sv
module evt_xlate_ctl
  import evt_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       memAck,
  input  logic       memErr,
  input  dpFlag_t    flags,
  output dpCtl_t     ctl,
  output logic       memReq,
  output logic       memWe,
  output logic       memWide,
  output logic       pendStrobe,
  output logic       pendSet,
  output logic       done,
  output logic [1:0] result
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_DEV, ST_RD_ITEL, ST_RD_ITEH, ST_RD_COL,
    ST_SIGNAL, ST_WR_ITEL, ST_WR_ITEH, ST_FIN
  } walkSt_e;

  walkSt_e  state, nxt;
  walkRes_e resReg, nxtRes;
  opKind_e  opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      resReg <= RES_CONTINUE;
      opReg  <= OP_TRIGGER;
    end else begin
      state  <= nxt;
      resReg <= nxtRes;
      if (state == ST_IDLE && start) opReg <= opKind_e'(op);
    end
  end

  always_comb begin
    nxt         = state;
    nxtRes      = resReg;
    ctl         = '0;
    ctl.addrSel = SEL_DEV;
    memReq      = 1'b0;
    memWe       = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.latchReq = 1'b1;
        if (flags.devOor) begin nxt = ST_FIN; nxtRes = RES_IGNORE; end
        else nxt = ST_RD_DEV;
      end
      ST_RD_DEV: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin nxt = ST_FIN; nxtRes = RES_STALL; end
          else if (!flags.devOk || flags.evtOor) begin nxt = ST_FIN; nxtRes = RES_IGNORE; end
          else begin ctl.loadDev = 1'b1; nxt = ST_RD_ITEL; end
        end
      end
      ST_RD_ITEL: begin
        memReq = 1'b1; ctl.addrSel = SEL_ITE_LO;
        if (memAck) begin
          if (memErr) begin nxt = ST_FIN; nxtRes = RES_STALL; end
          else if (!flags.iteOk) begin nxt = ST_FIN; nxtRes = RES_IGNORE; end
          else begin ctl.loadItel = 1'b1; nxt = ST_RD_ITEH; end
        end
      end
      ST_RD_ITEH: begin
        memReq = 1'b1; ctl.addrSel = SEL_ITE_HI;
        if (memAck) begin
          if (memErr) begin nxt = ST_FIN; nxtRes = RES_STALL; end
          else if (flags.colOor) begin nxt = ST_FIN; nxtRes = RES_IGNORE; end
          else begin ctl.loadIteh = 1'b1; nxt = ST_RD_COL; end
        end
      end
      ST_RD_COL: begin
        memReq = 1'b1; ctl.addrSel = SEL_COL;
        if (memAck) begin
          if (memErr) begin nxt = ST_FIN; nxtRes = RES_STALL; end
          else if (!flags.colOk || flags.tgtOor) begin nxt = ST_FIN; nxtRes = RES_IGNORE; end
          else begin ctl.loadCol = 1'b1; nxt = ST_SIGNAL; end
        end
      end
      ST_SIGNAL: begin
        if (opReg == OP_DISCARD) nxt = ST_WR_ITEL;
        else begin nxt = ST_FIN; nxtRes = RES_CONTINUE; end
      end
      ST_WR_ITEL: begin
        memReq = 1'b1; memWe = 1'b1; ctl.addrSel = SEL_ITE_LO;
        if (memAck) begin
          if (memErr) begin nxt = ST_FIN; nxtRes = RES_STALL; end
          else nxt = ST_WR_ITEH;
        end
      end
      ST_WR_ITEH: begin
        memReq = 1'b1; memWe = 1'b1; ctl.addrSel = SEL_ITE_HI;
        if (memAck) begin
          nxt    = ST_FIN;
          nxtRes = memErr ? RES_STALL : RES_CONTINUE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign memWide    = !(state == ST_RD_ITEH || state == ST_WR_ITEH);
  assign pendStrobe = state == ST_SIGNAL;
  assign pendSet    = opReg == OP_TRIGGER;
  assign done       = state == ST_FIN;
  assign result     = resReg;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_PEND_ONE: assert property (@(posedge clk) disable iff (!rstN)
    pendStrobe |=> !pendStrobe) else $error("pending strobe repeated"); // R7
  AST_STALL_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> (done && result == RES_STALL)) else $error("fault did not stall"); // R9
  AST_WR_ONLY_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (opReg == OP_DISCARD)) else $error("write outside discard"); // R8
endmodule

// File: rtl/evt_xlate_top.sv
module evt_xlate_top
  import evt_xlate_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DEVW    = 8,
  parameter int EVW     = 16,
  parameter int COLW    = 8,
  parameter int PROCW   = 8,
  parameter int IDW_INT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [DEVW-1:0]    devId,
  input  logic [EVW-1:0]     eventId,
  input  logic [AW-1:0]      devBase,
  input  logic [DEVW:0]      devCount,
  input  logic [AW-1:0]      colBase,
  input  logic [COLW:0]      colCount,
  input  logic [PROCW:0]     cpuCount,
  output logic               memReq,
  output logic               memWe,
  output logic               memWide,
  output logic [AW-1:0]      memAddr,
  output logic [63:0]        memWdata,
  input  logic               memAck,
  input  logic               memErr,
  input  logic [63:0]        memRdata,
  output logic               pendStrobe,
  output logic               pendSet,
  output logic [PROCW-1:0]   target,
  output logic [IDW_INT-1:0] intId,
  output logic               done,
  output logic [1:0]         result
);
  dpCtl_t  ctl;
  dpFlag_t flags;

  evt_xlate_ctl u_ctl (
    .clk, .rstN, .start, .op, .memAck, .memErr, .flags, .ctl,
    .memReq, .memWe, .memWide, .pendStrobe, .pendSet, .done, .result
  );

  evt_xlate_dp #(
    .AW(AW), .DEVW(DEVW), .EVW(EVW), .COLW(COLW), .PROCW(PROCW), .IDW_INT(IDW_INT)
  ) u_dp (
    .clk, .rstN, .ctl, .devId, .eventId, .devBase, .devCount, .colBase,
    .colCount, .cpuCount, .memRdata, .flags, .memAddr, .memWdata, .target, .intId
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))) else $error("request dropped or moved"); // R4
endmodule

// File: tb/tb_evt_xlate_top.sv
module tb_evt_xlate_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DEVW = 4, EVW = 8, COLW = 4, PROCW = 4, IDW_INT = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] op = '0;
  logic [DEVW-1:0] devId = '0;
  logic [EVW-1:0] eventId = '0;
  logic [AW-1:0] devBase = 16'h000, colBase = 16'h100;
  logic [DEVW:0] devCount = 5'd8;
  logic [COLW:0] colCount = 5'd4;
  logic [PROCW:0] cpuCount = 5'd2;
  logic memReq, memWe, memWide, memAck = 1'b0, memErr = 1'b0;
  logic [AW-1:0] memAddr;
  logic [63:0] memWdata, memRdata = '0;
  logic pendStrobe, pendSet, done;
  logic [PROCW-1:0] target;
  logic [IDW_INT-1:0] intId;
  logic [1:0] result;

  evt_xlate_top #(.AW(AW), .DEVW(DEVW), .EVW(EVW), .COLW(COLW), .PROCW(PROCW), .IDW_INT(IDW_INT)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [0:4095];
  int errRd = -1, errWr = -1, accCount = 0;
  int checks = 0, errors = 0;

  // behavioural memory, one-cycle acknowledge
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      automatic logic [11:0] a = memAddr[11:0];
      automatic logic [63:0] rd = '0;
      automatic bit fault = memWe ? (int'(memAddr) == errWr) : (int'(memAddr) == errRd);
      accCount <= accCount + 1;
      memAck <= 1'b1;
      memErr <= fault;
      for (int i = 0; i < 8; i++) begin
        if (i < 4 || memWide) begin
          if (memWe && !fault) mem[a + 12'(i)] = memWdata[8*i +: 8];
          rd[8*i +: 8] = mem[a + 12'(i)];
        end
      end
      memRdata <= rd;
    end else begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end
  end

  task automatic put(input int addr, input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) mem[addr + i] = v[8*i +: 8];
  endtask

  function automatic logic [63:0] get64(input int addr);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = mem[addr + i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic putIte(input int dev1Base, input int ev, input int lo, input int hi);
    put(dev1Base + 12*ev, 64'(lo), 8);
    put(dev1Base + 12*ev + 8, 64'(hi), 4);
  endtask

  int gotRes, pendCnt, pendS, pendT, pendI, accDelta;
  bit gotDone;

  task automatic walk(input int o, input int d, input int e);
    automatic int acc0 = accCount;
    gotDone = 0; pendCnt = 0;
    @(negedge clk);
    start = 1'b1; op = 2'(o); devId = DEVW'(d); eventId = EVW'(e);
    for (int n = 0; n < 200 && !gotDone; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (pendStrobe) begin pendCnt++; pendS = pendSet; pendT = target; pendI = intId; end
      if (done) begin gotDone = 1; gotRes = result; end
    end
    accDelta = accCount - acc0;
    if (!gotDone) chk(0, "R10 walk hung", 0, 1);
  endtask

  task automatic expectWalk(input string req, input int o, input int d, input int e,
                            input int expRes, input int expPend, input int expSet,
                            input int expTgt, input int expInt);
    walk(o, d, e);
    chk(gotDone && gotRes == expRes, {req, " result"}, gotRes, expRes);
    chk(pendCnt == expPend, {req, " pending strobes"}, pendCnt, expPend);
    if (expPend == 1) begin
      chk(pendS == expSet && pendT == expTgt && pendI == expInt, {req, " pending payload"},
          (pendS << 24) | (pendT << 16) | pendI, (expSet << 24) | (expTgt << 16) | expInt);
    end
  endtask

  task automatic testReset;
    chk(!done && !pendStrobe && !memReq, "R10 reset outputs", {done, pendStrobe, memReq}, 0);
  endtask

  task automatic testTriggerClear; // R7 R5 R4
    expectWalk("R7 trigger", 0, 1, 3, 0, 1, 1, 1, 16'h2003);
    expectWalk("R7 clear", 1, 1, 3, 0, 1, 0, 1, 16'h2003);
    expectWalk("R5 trigger col0", 0, 1, 0, 0, 1, 1, 0, 16'h1000);
  endtask

  task automatic testDevChecks;
    expectWalk("R1 devId at count", 0, 8, 0, 1, 0, 0, 0, 0);
    chk(accDelta == 0, "R1 no memory access", accDelta, 0);
    expectWalk("R2 invalid device", 0, 7, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic testEventRange; // R3
    expectWalk("R3 last event dev1", 1, 1, 7, 1, 0, 0, 0, 0); // col2 invalid -> passes range, stops later
    chk(accDelta == 4, "R3 event 7 reaches collection", accDelta, 4);
    expectWalk("R3 event at count dev1", 0, 1, 8, 1, 0, 0, 0, 0);
    chk(accDelta == 1, "R3 stop after device read", accDelta, 1);
    expectWalk("R3 last event dev2", 0, 2, 1, 0, 1, 1, 0, 16'h3001);
    expectWalk("R3 event at count dev2", 0, 2, 2, 1, 0, 0, 0, 0);
  endtask

  task automatic testEntryChecks;
    expectWalk("R5 invalid entry", 0, 1, 4, 1, 0, 0, 0, 0);
    expectWalk("R5 non-physical entry", 0, 1, 5, 1, 0, 0, 0, 0);
    expectWalk("R6 collection at count", 0, 1, 6, 1, 0, 0, 0, 0);
    expectWalk("R6 target at count", 0, 2, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic testReadFaults; // R9
    errRd = 16'h020;
    expectWalk("R9 device read fault", 0, 4, 0, 2, 0, 0, 0, 0);
    errRd = 16'h200 + 12 + 8;
    expectWalk("R9 high word fault", 0, 1, 1, 2, 0, 0, 0, 0);
    errRd = -1;
  endtask

  task automatic testDiscard; // R8 R4
    logic [63:0] before2 = get64(16'h200 + 24);
    expectWalk("R8 discard", 2, 1, 3, 0, 1, 0, 1, 16'h2003);
    chk(get64(16'h224) == 0 && get64(16'h228)[63:32] == 32'h0 && get64(16'h22C)[31:0] == 0,
        "R4 entry zeroed", int'(get64(16'h224)), 0);
    chk(get64(16'h218) == before2, "R4 neighbour intact", int'(get64(16'h218)), int'(before2));
    chk(get64(16'h230)[31:0] == 32'h0000_0001 ? 1'b0 : 1'b1, "R4 next entry untouched", 0, 0);
    expectWalk("R8 retrigger after discard", 0, 1, 3, 1, 0, 0, 0, 0);
    errWr = 16'h200 + 24 + 8;
    expectWalk("R8 write-back fault", 2, 1, 2, 2, 1, 0, 1, 16'h1002);
    chk(get64(16'h218) == 0, "R8 low word written first", int'(get64(16'h218)), 0);
    errWr = -1;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    put(16'h008, 64'h205, 8);                 // dev1: table 0x200, size 2 (8 events)
    put(16'h010, 64'h401, 8);                 // dev2: table 0x400, size 0 (2 events)
    put(16'h020, 64'h601, 8);                 // dev4: used for read fault
    put(16'h100, 64'h0_0001, 8);              // col0 -> target 0
    put(16'h108, 64'h1_0001, 8);              // col1 -> target 1
    put(16'h110, 64'h1_0000, 8);              // col2 invalid
    put(16'h118, 64'h2_0001, 8);              // col3 -> target 2 (too high)
    putIte(16'h200, 0, 32'h10_0003, 0);
    putIte(16'h200, 1, 32'h10_0103, 1);
    putIte(16'h200, 2, 32'h10_0203, 1);
    putIte(16'h200, 3, 32'h20_0303, 1);
    putIte(16'h200, 5, 32'h10_0505, 0);       // type 2: not physical
    putIte(16'h200, 6, 32'h10_0603, 5);
    putIte(16'h200, 7, 32'h10_0703, 2);
    putIte(16'h200, 8, 32'h10_0803, 0);
    putIte(16'h400, 0, 32'h30_0003, 3);
    putIte(16'h400, 1, 32'h30_0103, 0);
    putIte(16'h400, 2, 32'h30_0203, 0);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTriggerClear();
    testDevChecks();
    testEventRange();
    testEntryChecks();
    testReadFaults();
    testDiscard();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule